// File: doc/BRIEF.md
# Clock PLL Bring-Up Sequencer

This block drives a 32-bit clock-control register through an ordered PLL start-up sequence. It begins on a start pulse. At that edge it captures the current register value, the receive and transmit lane-width modes and four 2-bit multipliers. It then issues four read-modify-write values on a register write port, one per cycle.

The four values do the following, in order:
- Write one forces every PLL into powerdown and bypass.
- Write two programs the dual-clock selects and the multipliers.
- Write three releases bypass.
- Write four releases powerdown.

The second PLL of a direction is touched only when that direction runs in dual-clock mode.

After the last write, the block pulses a unit reset output for one cycle. It then waits a fixed settling time without looking at any lock indication, and raises a done flag. The settling time is the number of clock cycles per microsecond multiplied by a microsecond count. The done flag stays high until the next start pulse.

Top module: `pll_seq_top`

## Requirements
- R1: After reset, reg_wr, unit_rst and done are all 0.
- R2: A width code of 2'b00 means a single 32-bit lane (single-clock). Codes 2'b01, 2'b10 and 2'b11 put that direction in dual-clock mode.
- R3: The first write carries the reg_rdata value sampled at the accepted start edge, with bits 15:12 and 7:4 forced to 1 (OR with 0x0000F0F0).
- R4: The second write equals the first with bits 25:16 replaced. Bit 24 is receive dual, bit 25 is transmit dual. Bits 17:16, 19:18, 21:20 and 23:22 hold rx01_mul, rx23_mul, tx01_mul and tx23_mul.
- R5: The third write equals the second with bits 12 and 14 cleared. Bit 13 is also cleared when receive is dual, and bit 15 when transmit is dual.
- R6: The fourth write equals the third with bits 4 and 6 cleared. Bit 5 is also cleared when receive is dual, and bit 7 when transmit is dual.
- R7: Exactly four one-cycle reg_wr strobes occur per sequence. They fall in consecutive cycles, the first in the cycle after the accepted start edge.
- R8: unit_rst is high for exactly one cycle, the cycle right after the fourth write.
- R9: done rises after CYC_PER_US*WAIT_US cycles following the unit_rst cycle, with no write and no reset pulse in between.
- R10: done stays high while start is low, whatever the other inputs do. A start while done is high begins a new sequence and drops done.
- R11: A start pulse during a sequence is ignored. The sequence's values, its timing and its captured configuration are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start request, accepted only when idle or done |
| rx_width | input | 2 | Receive lane-width mode |
| tx_width | input | 2 | Transmit lane-width mode |
| rx01_mul | input | 2 | Multiplier for receive clocks 0/1 |
| rx23_mul | input | 2 | Multiplier for receive clocks 2/3 |
| tx01_mul | input | 2 | Multiplier for transmit clocks 0/1 |
| tx23_mul | input | 2 | Multiplier for transmit clocks 2/3 |
| reg_rdata | input | 32 | Current clock-control register value |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 32 | Value to write |
| unit_rst | output | 1 | One-cycle unit reset pulse |
| done | output | 1 | Sequence complete, held until next start |

## Verification
A wrong state in the sequencer shows within one cycle as a strobe in the wrong cycle or a write value with misplaced bits. Every write is compared bit-for-bit against an arithmetic model for all sixteen width combinations.

A miscaptured configuration surfaces in writes two to four. This is probed by pulsing start with different inputs partway through a sequence. A miscounting wait timer shows as done rising one or more cycles off the expected cycle, or as done dropping while it should be held.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR1,
        ST_WR2,
        ST_WR3,
        ST_WR4,
        ST_URST,
        ST_WAIT,
        ST_DONE
    } seq_state_e;

    // Configuration captured at an accepted start
    typedef struct packed {
        logic       rx_dual;
        logic       tx_dual;
        logic [7:0] mul;     // {tx23, tx01, rx23, rx01}
    } seq_cfg_t;

    typedef struct packed {
        seq_state_e  state;
        logic [31:0] val;
        seq_cfg_t    cfg;
        logic        done;
    } seq_regs_t;

    localparam logic [31:0] FORCE_OFF_MASK = 32'h0000_F0F0;
    localparam logic [31:0] CFG_FIELD_MASK = 32'h03FF_0000;
    localparam logic [31:0] BYP_BASE_MASK  = 32'h0000_5000;
    localparam logic [31:0] PWR_BASE_MASK  = 32'h0000_0050;

endpackage

// File: rtl/pll_seq_step.sv
module pll_seq_step
    import pll_seq_pkg::*;
(
    input  logic [1:0]  step_sel,
    input  logic [31:0] base_val,
    input  seq_cfg_t    cfg,
    output logic [31:0] next_val
);
    logic [31:0] rx_bit;
    logic [31:0] tx_bit;

    always_comb begin
        rx_bit = {31'd0, cfg.rx_dual};
        tx_bit = {31'd0, cfg.tx_dual};
        unique case (step_sel)
            2'd0: next_val = base_val | FORCE_OFF_MASK;
            2'd1: next_val = (base_val & ~CFG_FIELD_MASK)
                           | (tx_bit << 25) | (rx_bit << 24)
                           | ({24'd0, cfg.mul} << 16);
            2'd2: next_val = base_val & ~(BYP_BASE_MASK | (rx_bit << 13) | (tx_bit << 15));
            default: next_val = base_val & ~(PWR_BASE_MASK | (rx_bit << 5) | (tx_bit << 7));
        endcase
    end
endmodule

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
    parameter int unsigned WAIT_CYC = 12500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int unsigned CW = $clog2(WAIT_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(WAIT_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        expire = run && (cnt_q == LAST);
        if (!run || expire) cnt_d = '0;
        else                cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_TMR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST); // R9
    AST_TMR_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt_q == '0); // R9
endmodule

// File: rtl/pll_seq_top.sv
module pll_seq_top
    import pll_seq_pkg::*;
#(
    parameter int unsigned CYC_PER_US = 125,
    parameter int unsigned WAIT_US    = 100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [1:0]  rx_width,
    input  logic [1:0]  tx_width,
    input  logic [1:0]  rx01_mul,
    input  logic [1:0]  rx23_mul,
    input  logic [1:0]  tx01_mul,
    input  logic [1:0]  tx23_mul,
    input  logic [31:0] reg_rdata,
    output logic        reg_wr,
    output logic [31:0] reg_wdata,
    output logic        unit_rst,
    output logic        done
);
    localparam int unsigned WAIT_CYC = CYC_PER_US * WAIT_US;

    seq_regs_t   r_d, r_q;
    logic [1:0]  step_sel;
    logic [31:0] step_base;
    logic [31:0] step_out;
    logic        wait_expire;
    logic        start_ok;

    pll_seq_step u_step (
        .step_sel (step_sel),
        .base_val (step_base),
        .cfg      (r_q.cfg),
        .next_val (step_out)
    );

    pll_seq_timer #(.WAIT_CYC(WAIT_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (r_q.state == ST_WAIT),
        .expire (wait_expire)
    );

    always_comb begin
        r_d      = r_q;
        start_ok = start && (r_q.state == ST_IDLE || r_q.state == ST_DONE);
        step_sel = 2'd0;
        step_base = r_q.val;
        unique case (r_q.state)
            ST_IDLE, ST_DONE: begin
                step_base = reg_rdata;
                if (start_ok) begin
                    r_d.state       = ST_WR1;
                    r_d.val         = step_out;
                    r_d.cfg.rx_dual = (rx_width != 2'b00);
                    r_d.cfg.tx_dual = (tx_width != 2'b00);
                    r_d.cfg.mul     = {tx23_mul, tx01_mul, rx23_mul, rx01_mul};
                    r_d.done        = 1'b0;
                end
            end
            ST_WR1: begin
                step_sel  = 2'd1;
                r_d.val   = step_out;
                r_d.state = ST_WR2;
            end
            ST_WR2: begin
                step_sel  = 2'd2;
                r_d.val   = step_out;
                r_d.state = ST_WR3;
            end
            ST_WR3: begin
                step_sel  = 2'd3;
                r_d.val   = step_out;
                r_d.state = ST_WR4;
            end
            ST_WR4:  r_d.state = ST_URST;
            ST_URST: r_d.state = ST_WAIT;
            ST_WAIT: begin
                if (wait_expire) begin
                    r_d.state = ST_DONE;
                    r_d.done  = 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.val   <= '0;
            r_q.cfg   <= '0;
            r_q.done  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign reg_wr    = (r_q.state == ST_WR1) || (r_q.state == ST_WR2)
                    || (r_q.state == ST_WR3) || (r_q.state == ST_WR4);
    assign reg_wdata = r_q.val;
    assign unit_rst  = (r_q.state == ST_URST);
    assign done      = r_q.done;

    AST_FIRST_WR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_wr) |-> (reg_wdata[15:12] == 4'hF && reg_wdata[7:4] == 4'hF)); // R3
    AST_LATER_WR_ONLY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && $past(reg_wr)) |-> ((reg_wdata[15:0] & ~$past(reg_wdata[15:0])) == 16'h0)); // R5
    AST_RST_AFTER_LAST_WR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(reg_wr) |-> unit_rst); // R8
    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        unit_rst |=> !unit_rst); // R8
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!reg_wr && !unit_rst)); // R9
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done); // R10
    AST_WR_NOT_WITH_RST: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && unit_rst)); // R7
endmodule

// File: tb/pll_seq_top_tb_top.sv
module pll_seq_top_tb_top;
    localparam int unsigned CPU = 3;
    localparam int unsigned WUS = 2;
    localparam int unsigned WCYC = CPU * WUS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  rx_width = '0, tx_width = '0;
    logic [1:0]  rx01_mul = '0, rx23_mul = '0, tx01_mul = '0, tx23_mul = '0;
    logic [31:0] reg_rdata = '0;
    logic        reg_wr, unit_rst, done;
    logic [31:0] reg_wdata;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    pll_seq_top #(.CYC_PER_US(CPU), .WAIT_US(WUS)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .rx_width(rx_width), .tx_width(tx_width),
        .rx01_mul(rx01_mul), .rx23_mul(rx23_mul),
        .tx01_mul(tx01_mul), .tx23_mul(tx23_mul),
        .reg_rdata(reg_rdata), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .unit_rst(unit_rst), .done(done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic ctl(input string req, input logic w, input logic r, input logic d);
        chk(req, {29'd0, reg_wr, unit_rst, done}, {29'd0, w, r, d});
    endtask

    // One full sequence; optionally a disturbing start arrives mid-sequence
    task automatic run_seq(input logic [1:0] rw, input logic [1:0] tw,
                           input logic [7:0] m, input logic [31:0] rd,
                           input bit inject);
        logic rxd, txd;
        logic [31:0] e1, e2, e3, e4;
        rxd = (rw != 2'b00);          // R2
        txd = (tw != 2'b00);
        e1 = rd | 32'h0000_F0F0;
        e2 = (e1 & 32'hFC00_FFFF) | ({31'd0, txd} << 25) | ({31'd0, rxd} << 24)
           | ({24'd0, m} << 16);
        e3 = e2 & ~(32'h5000 | ({31'd0, rxd} << 13) | ({31'd0, txd} << 15));
        e4 = e3 & ~(32'h0050 | ({31'd0, rxd} << 5) | ({31'd0, txd} << 7));

        @(negedge clk);
        rx_width = rw; tx_width = tw;
        {tx23_mul, tx01_mul, rx23_mul, rx01_mul} = m;
        reg_rdata = rd;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        reg_rdata = ~rd;
        chk("R10 done drops on restart", {31'd0, done}, 32'd0);
        ctl("R7 strobe 1", 1'b1, 1'b0, 1'b0);
        chk("R3 write one", reg_wdata, e1);
        if (inject) begin
            rx_width = ~rw; tx_width = ~tw;
            {tx23_mul, tx01_mul, rx23_mul, rx01_mul} = ~m;
            start = 1'b1;
        end
        @(negedge clk);
        start = 1'b0;
        ctl("R7 strobe 2", 1'b1, 1'b0, 1'b0);
        chk(inject ? "R11 write two after ignored start" : "R4 write two", reg_wdata, e2);
        @(negedge clk);
        if (inject) start = 1'b1;
        ctl("R7 strobe 3", 1'b1, 1'b0, 1'b0);
        chk(inject ? "R11 write three" : "R5 write three", reg_wdata, e3);
        @(negedge clk);
        start = 1'b0;
        ctl("R7 strobe 4", 1'b1, 1'b0, 1'b0);
        chk(inject ? "R11 write four" : "R6 write four", reg_wdata, e4);
        @(negedge clk);
        ctl("R8 unit reset pulse", 1'b0, 1'b1, 1'b0);
        for (int k = 0; k < WCYC; k++) begin
            if (inject && k == 1) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            ctl("R9 waiting", 1'b0, 1'b0, 1'b0);
        end
        @(negedge clk);
        ctl("R9 done rises", 1'b0, 1'b0, 1'b1);
        reg_rdata = 32'hDEAD_BEEF;
        rx_width = 2'b11;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            ctl("R10 done held", 1'b0, 1'b0, 1'b1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        ctl("R1 reset state", 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        ctl("R1 idle after reset", 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 16; i++) begin
            run_seq(i[3:2], i[1:0], 8'(i * 37 + 5),
                    32'hA5C3_0F0F ^ (32'(i) * 32'h0123_4567), (i % 3) == 1);
        end
        run_seq(2'b00, 2'b00, 8'hFF, 32'hFFFF_FFFF, 1'b0);
        run_seq(2'b11, 2'b11, 8'h00, 32'h0000_0000, 1'b1);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule